// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits on the receive path of an Ethernet MAC. It decides from the destination address of an incoming frame whether that frame is kept. The six destination bytes arrive one per valid cycle, and a strobe marks the first byte. While the bytes stream in, the block builds a CRC-32 over them and keeps a copy of the address. The cycle after the last byte, it gives a one-cycle decision strobe together with an accept flag.

Unicast addresses are compared against a programmed 48-bit station address. The all-ones broadcast address is controlled by its own enable. Any other group address is looked up in a 64-bucket hash table, stored as two 32-bit words and indexed by the top six bits of the CRC. A promiscuous control accepts every frame. An all-multicast control accepts every group address without looking at the table. A simple write port programs the table, the station address and the controls.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash is a CRC-32 over the six address bytes, taken in arrival order. The register starts at all ones. The bits of each byte enter least significant bit first. For each bit the register shifts left and is XORed with polynomial 0x04C11DB7 when (register bit 31 XOR data bit) is 1. No final inversion is applied.
- R2: For a group address that is not broadcast, with promiscuous and all-multicast off, the bucket comes from the CRC. CRC bit 31 picks the table word (0 selects the word at address 0, 1 selects the word at address 1). CRC bits 30..26 give the bit index 0..31 in that word. The frame is accepted exactly when that table bit is 1.
- R3: Write map by word address. Addresses 0 and 1 are the two hash words. Address 2 is station bytes 2..5, with byte 2 in bits 31:24 and byte 5 in bits 7:0. Address 3 bits 15:8 are station byte 0 and bits 7:0 are byte 1; its upper bits are ignored. Address 4 is the control word: bit 0 promiscuous, bit 1 all-multicast, bit 2 broadcast enable. Writes to addresses 5 to 7 change nothing.
- R4: With both hash words zero and promiscuous and all-multicast off, every non-broadcast group address is rejected.
- R5: With promiscuous on, every frame is accepted, whatever the table, station address or broadcast enable.
- R6: With all-multicast on, every non-broadcast group address (bit 0 of the first byte set) is accepted, whatever the table.
- R7: Without promiscuous, the all-ones address is accepted exactly when broadcast enable is set, whatever the table and all-multicast.
- R8: Without promiscuous, a unicast address (bit 0 of the first byte clear) is accepted exactly when all 48 bits equal the station address.
- R9: A byte with the first strobe starts a new address and abandons any partial one. Bytes count only when valid. Valid bytes outside an address are ignored. dec_valid is high for exactly one cycle: the cycle after the sixth byte.
- R10: After reset, dec_valid is low and all registers are zero. So broadcast and group addresses are rejected and the all-zero unicast address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Address byte present this cycle |
| byte_first | input | 1 | Marks the first byte of a destination address |
| byte_data | input | 8 | Address byte, first byte of the address first |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_accept | output | 1 | Accept flag, meaningful while dec_valid is high |

## Verification
The hash path is swept bucket by bucket. For each of the 64 buckets only that table bit is set, and a batch of pseudo-random group addresses is pushed through. This separates errors in CRC bit order, the word-select bit and the in-word index, because any of them moves an accepted address into the wrong bucket. The unicast compare is tested with every single-bit corruption of the station address, which exposes any byte or bit misplacement in the station registers. Broadcast and group addresses are run under each mode, and the mode overrides are told apart by setting the controls against each other: a full table with broadcast disabled, and all-multicast with an empty table. Separate runs with gaps between bytes, with a restarted address and with stray bytes check the decision timing.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned ADDR_BYTES = 6;
    localparam int unsigned MAC_W      = BYTE_W * ADDR_BYTES;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned HASH_WORDS = 2;
    localparam int unsigned CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_INIT = '1;

    localparam int unsigned SEL_W  = $clog2(HASH_WORDS);
    localparam int unsigned IDX_W  = $clog2(WORD_W);
    localparam int unsigned HBITS  = SEL_W + IDX_W;
    localparam int unsigned CNT_W  = $clog2(ADDR_BYTES);
    localparam int unsigned CFG_AW = 3;

    localparam int unsigned STA_LO_ADDR = HASH_WORDS;
    localparam int unsigned STA_HI_ADDR = HASH_WORDS + 1;
    localparam int unsigned CTRL_ADDR   = HASH_WORDS + 2;

    typedef struct packed {
        logic bcast_en;   // bit 2
        logic allmulti;   // bit 1
        logic promisc;    // bit 0
    } ctrl_t;

    typedef struct packed {
        logic [HASH_WORDS-1:0][WORD_W-1:0] hash;
        logic [MAC_W-1:0]                  station;
        ctrl_t                             ctrl;
    } cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CRC_W-1:0] crc;
        logic [MAC_W-1:0] addr;
        logic             done;
    } col_t;

endpackage

// File: rtl/mhf_crc_step.sv
module mhf_crc_step #(
    parameter int unsigned CRC_W = 32,
    parameter int unsigned BYTE_W = 8,
    parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CRC_W-1:0]  crc_o
);
    // One byte per call, bits fed least significant first, MSB-first register.
    logic [CRC_W-1:0] chain [BYTE_W+1];

    assign chain[0] = crc_i;

    for (genvar j = 0; j < BYTE_W; j++) begin : g_bit
        logic fb;
        assign fb = chain[j][CRC_W-1] ^ byte_i[j];
        assign chain[j+1] = {chain[j][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_o = chain[BYTE_W];
endmodule

// File: rtl/mhf_cfg_regs.sv
module mhf_cfg_regs
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output cfg_t              cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            for (int w = 0; w < HASH_WORDS; w++) begin
                if (cfg_addr == CFG_AW'(w)) cfg_d.hash[w] = cfg_wdata;
            end
            if (cfg_addr == CFG_AW'(STA_LO_ADDR))
                cfg_d.station[WORD_W-1:0] = cfg_wdata;
            if (cfg_addr == CFG_AW'(STA_HI_ADDR))
                cfg_d.station[MAC_W-1:WORD_W] = cfg_wdata[MAC_W-WORD_W-1:0];
            if (cfg_addr == CFG_AW'(CTRL_ADDR))
                cfg_d.ctrl = ctrl_t'(cfg_wdata[$bits(ctrl_t)-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // Writes above the control word leave every register untouched.
    assert_reserved_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr > CFG_AW'(CTRL_ADDR)) |=> $stable(cfg_q));
endmodule

// File: rtl/mhf_collect.sv
module mhf_collect
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              done_o,
    output logic [MAC_W-1:0]  addr_o,
    output logic [HBITS-1:0]  bucket_o
);
    col_t col_d, col_q;
    logic [CRC_W-1:0] crc_base, crc_next;
    logic [MAC_W-1:0] addr_shift;

    assign crc_base   = in_first ? CRC_INIT : col_q.crc;
    assign addr_shift = {col_q.addr[MAC_W-BYTE_W-1:0], in_byte};

    mhf_crc_step #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(CRC_POLY)) u_crc (
        .crc_i (crc_base),
        .byte_i(in_byte),
        .crc_o (crc_next)
    );

    always_comb begin
        col_d      = col_q;
        col_d.done = 1'b0;
        if (in_valid) begin
            if (in_first) begin
                col_d.crc  = crc_next;
                col_d.addr = addr_shift;
                col_d.cnt  = CNT_W'(1);
            end else if (col_q.cnt != '0) begin
                col_d.crc  = crc_next;
                col_d.addr = addr_shift;
                if (col_q.cnt == CNT_W'(ADDR_BYTES - 1)) begin
                    col_d.cnt  = '0;
                    col_d.done = 1'b1;
                end else begin
                    col_d.cnt = col_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    assign done_o   = col_q.done;
    assign addr_o   = col_q.addr;
    assign bucket_o = col_q.crc[CRC_W-1 -: HBITS];

    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        col_q.cnt < CNT_W'(ADDR_BYTES));
    assert_done_after_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        col_q.done |-> $past(in_valid));
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
    import mhf_pkg::*;
(
    input  logic [MAC_W-1:0] addr_i,
    input  logic [HBITS-1:0] bucket_i,
    input  cfg_t             cfg_i,
    output logic             is_bcast_o,
    output logic             is_group_o,
    output logic             accept_o
);
    logic [SEL_W-1:0] word_sel;
    logic [IDX_W-1:0] bit_sel;
    logic             hash_hit;

    assign word_sel   = bucket_i[HBITS-1 -: SEL_W];
    assign bit_sel    = bucket_i[IDX_W-1:0];
    assign hash_hit   = cfg_i.hash[word_sel][bit_sel];
    assign is_bcast_o = &addr_i;
    assign is_group_o = addr_i[MAC_W-BYTE_W];   // bit 0 of the first byte

    always_comb begin
        if (cfg_i.ctrl.promisc)  accept_o = 1'b1;
        else if (is_bcast_o)     accept_o = cfg_i.ctrl.bcast_en;
        else if (is_group_o)     accept_o = cfg_i.ctrl.allmulti | hash_hit;
        else                     accept_o = (addr_i == cfg_i.station);
    end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mhf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_valid,
    input  logic        byte_first,
    input  logic [7:0]  byte_data,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic        dec_valid,
    output logic        dec_accept
);
    cfg_t             cfg;
    logic             done;
    logic [MAC_W-1:0] addr;
    logic [HBITS-1:0] bucket;
    logic             is_bcast, is_group;

    mhf_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_o    (cfg)
    );

    mhf_collect u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(byte_valid),
        .in_first(byte_first),
        .in_byte (byte_data),
        .done_o  (done),
        .addr_o  (addr),
        .bucket_o(bucket)
    );

    mhf_decide u_dec (
        .addr_i    (addr),
        .bucket_i  (bucket),
        .cfg_i     (cfg),
        .is_bcast_o(is_bcast),
        .is_group_o(is_group),
        .accept_o  (dec_accept)
    );

    assign dec_valid = done;

    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);
    assert_promisc_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && cfg.ctrl.promisc) |-> dec_accept);
    assert_bcast_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && is_bcast && !cfg.ctrl.promisc) |-> (dec_accept == cfg.ctrl.bcast_en));
    assert_allmulti_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && cfg.ctrl.allmulti && is_group && !is_bcast) |-> dec_accept);
    assert_empty_table_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && cfg.hash == '0 && !cfg.ctrl.promisc && !cfg.ctrl.allmulti
         && is_group && !is_bcast) |-> !dec_accept);
endmodule

// File: tb/mcast_hash_filter_tb_top.sv
module mcast_hash_filter_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0, byte_first = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        dec_valid, dec_accept;

    mcast_hash_filter dut_i (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_first(byte_first),
        .byte_data(byte_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    int errors = 0, checks = 0;
    bit finished = 1'b0;
    logic [31:0] sh_h0 = '0, sh_h1 = '0;
    logic [47:0] sh_st = '0;
    logic [2:0]  sh_ctrl = '0;
    logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;

    function automatic logic [31:0] crc_be(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = a[47-8*i -: 8];
            for (int j = 0; j < 8; j++) begin
                logic cy = c[31] ^ b[j];
                c = {c[30:0], 1'b0};
                if (cy) c = c ^ 32'h04C11DB7;
            end
        end
        return c;
    endfunction

    function automatic logic exp_acc(input logic [47:0] a);
        logic [31:0] c;
        if (sh_ctrl[0]) return 1'b1;
        if (&a) return sh_ctrl[2];
        if (a[40]) begin
            if (sh_ctrl[1]) return 1'b1;
            c = crc_be(a);
            return c[31] ? sh_h1[c[30:26]] : sh_h0[c[30:26]];
        end
        return a == sh_st;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic set_hash(input logic [31:0] w0, input logic [31:0] w1);
        wr(3'd0, w0); wr(3'd1, w1); sh_h0 = w0; sh_h1 = w1;
    endtask

    task automatic set_station(input logic [47:0] s);
        wr(3'd2, s[31:0]); wr(3'd3, {16'hFFFF, s[47:32]}); sh_st = s;
    endtask

    task automatic set_ctrl(input logic [2:0] c);
        wr(3'd4, {29'h0, c}); sh_ctrl = c;
    endtask

    task automatic get_mc(output logic [47:0] a);
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        a = seed[63:16];
        a[40] = 1'b1;
        if (&a) a[0] = 1'b0;
    endtask

    task automatic send(input logic [47:0] a, input int gap, output logic acc, output bit tok);
        bit bad = 1'b0;
        logic v1, v2;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i > 0 && dec_valid) bad = 1'b1;
            byte_valid = 1'b1; byte_first = (i == 0); byte_data = a[47-8*i -: 8];
            if (i < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    if (dec_valid) bad = 1'b1;
                    byte_valid = 1'b0; byte_first = 1'b0;
                end
            end
        end
        @(negedge clk);
        byte_valid = 1'b0; byte_first = 1'b0;
        v1 = dec_valid; acc = dec_accept;
        @(negedge clk);
        v2 = dec_valid;
        tok = !bad && v1 && !v2;
    endtask

    task automatic frame(input logic [47:0] a, input string req);
        logic acc; bit tok;
        send(a, 0, acc, tok);
        check(tok, "R9", "decision strobe timing", 64'(tok), 64'd1);
        check(acc == exp_acc(a), req, $sformatf("accept for %012h", a), 64'(acc), 64'(exp_acc(a)));
    endtask

    initial begin
        logic [47:0] a;
        logic acc; bit tok; int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dec_valid == 1'b0, "R10", "dec_valid after reset", 64'(dec_valid), 64'd0);
        frame(48'hFFFF_FFFF_FFFF, "R10");
        frame(48'h0100_5E00_0001, "R10");
        frame(48'h0000_0000_0000, "R10");

        // R1 R2: one-bucket sweep over all 64 buckets
        for (int b = 0; b < 64; b++) begin
            set_hash(b < 32 ? (32'd1 << b) : 32'd0, b >= 32 ? (32'd1 << (b - 32)) : 32'd0);
            for (int k = 0; k < 24; k++) begin
                get_mc(a);
                frame(a, "R1/R2 bucket");
            end
        end

        // R4: empty table rejects every group address
        set_hash(32'h0, 32'h0);
        for (int k = 0; k < 32; k++) begin get_mc(a); frame(a, "R4"); end

        // R6: all-multicast with empty table
        set_ctrl(3'b010);
        for (int k = 0; k < 32; k++) begin get_mc(a); frame(a, "R6"); end
        frame(48'h0A00_0000_0001, "R8");

        // R5: promiscuous accepts everything, broadcast enable off
        set_ctrl(3'b001);
        get_mc(a); frame(a, "R5");
        frame(48'h0A12_3456_789A, "R5");
        frame(48'hFFFF_FFFF_FFFF, "R5");

        // R7: broadcast gate
        set_ctrl(3'b100);
        frame(48'hFFFF_FFFF_FFFF, "R7");
        set_hash(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        set_ctrl(3'b010);
        frame(48'hFFFF_FFFF_FFFF, "R7");
        set_ctrl(3'b000);
        frame(48'hFFFF_FFFF_FFFF, "R7");

        // R8 R3: station match and every single-bit corruption
        set_station(48'h0211_2233_4455);
        frame(48'h0211_2233_4455, "R8/R3");
        for (int i = 0; i < 48; i++) begin
            if (i != 40) frame(48'h0211_2233_4455 ^ (48'd1 << i), "R8");
        end

        // R3: reserved addresses have no effect
        set_hash(32'h0, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
        frame(48'hFFFF_FFFF_FFFF, "R3");
        get_mc(a); frame(a, "R3");
        frame(48'h0211_2233_4455, "R3");

        // R9: gaps between bytes
        set_hash(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        get_mc(a);
        send(a, 2, acc, tok);
        check(tok, "R9", "strobe with gaps", 64'(tok), 64'd1);
        check(acc == 1'b1, "R9", "accept with gaps", 64'(acc), 64'd1);

        // R9: restart abandons a partial address
        get_mc(a);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; byte_first = (i == 0); byte_data = a[47-8*i -: 8];
        end
        send(48'h0A00_0000_0002, 0, acc, tok);
        check(tok, "R9", "strobe after restart", 64'(tok), 64'd1);
        check(acc == 1'b0, "R9", "decision after restart", 64'(acc), 64'd0);

        // R9: stray bytes without a first strobe
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (dec_valid) seen++;
            byte_valid = 1'b1; byte_first = 1'b0; byte_data = 8'hFF;
        end
        @(negedge clk); byte_valid = 1'b0; if (dec_valid) seen++;
        @(negedge clk); if (dec_valid) seen++;
        check(seen == 0, "R9", "stray bytes strobes", 64'(seen), 64'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule